// File: doc/BRIEF.md
# Custom-Opcode Coprocessor Decode and Execute Unit

This block sits next to a 32-bit RISC-V core and takes instructions that the core offloads to it. Each offered instruction word arrives with up to three source operand values that the core has already read from its register file, and with the privilege level the core runs at. The unit decodes the word against a small fixed set of encodings in the custom-3 major opcode space. It either accepts the instruction and returns a result, a destination index or an exception cause, or it rejects it so that the core raises an illegal-instruction trap.

The supported operations are a two-operand add, a three-operand add (R4 layout), an add with a fixed multi-cycle latency, two adds that are legal only at user or supervisor privilege, a no-op that writes nothing, and an instruction that raises an exception whose cause is taken from its rs1 field. Requests use a valid/ready pair. Every taken request produces exactly one response pulse, in request order.

A control state machine has three states. ST_IDLE holds ready high and takes requests. Single-cycle operations answer in the following cycle and the machine stays in ST_IDLE. The transition ST_IDLE to ST_WAIT fires when a multi-cycle add is taken. ST_WAIT counts the latency and moves on to ST_DONE in its last counting cycle. ST_DONE presents the held result for one cycle and returns to ST_IDLE.

Top module: `xcop_exec`

## Requirements
- R1: A word whose bits [6:0] differ from 7'b1111011 is rejected. In the cycle after it is taken, rsp_valid_o is 1 while rsp_accept_o, rsp_we_o and rsp_exc_o are 0.
- R2: funct3 = bits [14:12] = 3'b001 with funct7 = bits [31:25] = 7'b0000000 is accepted. The response comes in the next cycle with rsp_we_o = 1, rsp_rd_o = bits [11:7] and rsp_data_o = (op_a_i + op_b_i) mod 2^32.
- R3: funct3 3'b000 with bits [26:25] = 2'b01 is the three-source add. Bits [31:27] name rs3, whose value arrives on op_c_i. The result is (op_a_i + op_b_i + op_c_i) mod 2^32, written to bits [11:7].
- R4: funct3 3'b000 with funct7 7'b0001000 is the multi-cycle add, with result op_a_i + op_b_i to bits [11:7]. After the cycle in which it is taken, req_ready_o stays low for 4 cycles. rsp_valid_o is high only in the 4th of those cycles, and req_ready_o is high again in the 5th.
- R5: funct3 3'b000 with funct7 7'b0000010 is the user add (op_a_i + op_b_i). It is accepted only when priv_i = 2'b00 and is rejected at any other privilege.
- R6: funct3 3'b000 with funct7 7'b0000110 is the supervisor add (op_a_i + op_b_i). It is accepted only when priv_i = 2'b01 and is rejected at any other privilege.
- R7: funct3 3'b010 with funct7 7'b1100000, rd = 0, rs2 = 0 and rs1 in {0..9, 11, 12, 13, 15} is accepted with rsp_exc_o = 1, rsp_cause_o = rs1 zero-extended to 6 bits, and rsp_we_o = 0.
- R8: The exception encoding is rejected, with no exception raised, when rs1 is 10, 14 or 16..31, or when rd or rs2 is non-zero.
- R9: funct3 3'b000 with funct7 7'b0000000 is the no-op. It is accepted with rsp_we_o = 0 and rsp_exc_o = 0.
- R10: Any other funct3/funct7 pair under the custom-3 opcode is rejected, with rsp_accept_o = 0 and no write or exception. Whenever rsp_we_o = 0, rsp_rd_o and rsp_data_o read 0.
- R11: After reset, req_ready_o = 1 and rsp_valid_o = 0. Single-cycle requests may be taken on consecutive cycles, and each gets one response, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Offered instruction is valid |
| req_ready_o | output | 1 | Unit can take an instruction this cycle |
| instr_i | input | 32 | Offloaded instruction word |
| op_a_i | input | 32 | Value of the rs1 register |
| op_b_i | input | 32 | Value of the rs2 register |
| op_c_i | input | 32 | Value of the rs3 register (three-source add only) |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_accept_o | output | 1 | Instruction accepted (0 means illegal) |
| rsp_we_o | output | 1 | Destination register is to be written |
| rsp_rd_o | output | 5 | Destination register index |
| rsp_data_o | output | 32 | Result value |
| rsp_exc_o | output | 1 | Instruction raises an exception |
| rsp_cause_o | output | 6 | Exception cause code |

## Verification
The bound checker watches every cycle for the following:
- Rejected responses stay quiet, and exception responses never write.
- Every exception cause lies in the legal set.
- A foreign opcode or a user add at the wrong privilege is answered with a rejection in the next cycle.
- Every single-cycle request is answered in the next cycle.
- The multi-cycle window holds ready low and places the result exactly at its end.

The arithmetic values, the destination indices, the supervisor and three-source decodes, the ordering of back-to-back responses and the reset state are shown only by the bench scenarios, which compare each response against a scoreboard entry.

// File: rtl/xcop_pkg.sv
package xcop_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned CAUSE_W   = 6;

    localparam logic [6:0] OPC_CUSTOM3 = 7'b1111011;

    localparam logic [2:0] F3_ARITH = 3'b000;
    localparam logic [2:0] F3_ADD   = 3'b001;
    localparam logic [2:0] F3_EXC   = 3'b010;

    localparam logic [6:0] F7_ZERO  = 7'b0000000;
    localparam logic [6:0] F7_MULTI = 7'b0001000;
    localparam logic [6:0] F7_UADD  = 7'b0000010;
    localparam logic [6:0] F7_SADD  = 7'b0000110;
    localparam logic [6:0] F7_EXC   = 7'b1100000;
    localparam logic [1:0] FMT_R4   = 2'b01;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADD,
        K_ADD3,
        K_MULTI,
        K_UADD,
        K_SADD,
        K_NOP,
        K_EXC
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE
    } ctrl_state_e;

    function automatic logic cause_known(input logic [REG_IDX_W-1:0] code);
        logic ok;
        unique case (code)
            5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
            5'd8, 5'd9, 5'd11, 5'd12, 5'd13, 5'd15: ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xcop_decode.sv
module xcop_decode
    import xcop_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    input  logic [1:0]      priv_i,
    output op_kind_e        kind_o
);

    logic [6:0]           opc;
    logic [6:0]           f7;
    logic [2:0]           f3;
    logic [REG_IDX_W-1:0] rd_f;
    logic [REG_IDX_W-1:0] rs1_f;
    logic [REG_IDX_W-1:0] rs2_f;

    assign opc   = instr_i[6:0];
    assign rd_f  = instr_i[11:7];
    assign f3    = instr_i[14:12];
    assign rs1_f = instr_i[19:15];
    assign rs2_f = instr_i[24:20];
    assign f7    = instr_i[31:25];

    always_comb begin
        kind_o = K_NONE;
        if (opc == OPC_CUSTOM3) begin
            unique case (f3)
                F3_ADD: begin
                    if (f7 == F7_ZERO) kind_o = K_ADD;
                end
                F3_ARITH: begin
                    if (f7[1:0] == FMT_R4)                          kind_o = K_ADD3;
                    else if (f7 == F7_ZERO)                         kind_o = K_NOP;
                    else if (f7 == F7_MULTI)                        kind_o = K_MULTI;
                    else if (f7 == F7_UADD && priv_i == PRIV_USER)  kind_o = K_UADD;
                    else if (f7 == F7_SADD && priv_i == PRIV_SUPER) kind_o = K_SADD;
                    else                                            kind_o = K_NONE;
                end
                F3_EXC: begin
                    if (f7 == F7_EXC && rd_f == '0 && rs2_f == '0 && cause_known(rs1_f))
                        kind_o = K_EXC;
                end
                default: kind_o = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/xcop_alu.sv
module xcop_alu
    import xcop_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  op_kind_e     kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] c_gated;

    assign c_gated = (kind_i == K_ADD3) ? c_i : '0;
    assign sum_o   = a_i + b_i + c_gated;

endmodule

// File: rtl/xcop_ctrl.sv
module xcop_ctrl
    import xcop_pkg::*;
#(
    parameter int unsigned MULTI_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  op_kind_e             kind_i,
    input  logic [REG_IDX_W-1:0] rd_idx_i,
    input  logic [REG_IDX_W-1:0] cause_src_i,
    input  logic [XLEN-1:0]      sum_i,
    output logic                 req_ready_o,
    output logic                 rsp_valid_o,
    output logic                 rsp_accept_o,
    output logic                 rsp_we_o,
    output logic [REG_IDX_W-1:0] rsp_rd_o,
    output logic [XLEN-1:0]      rsp_data_o,
    output logic                 rsp_exc_o,
    output logic [CAUSE_W-1:0]   rsp_cause_o
);

    localparam int unsigned CNT_W    = (MULTI_LAT > 2) ? $clog2(MULTI_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MULTI_LAT - 2);

    ctrl_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;
    logic             wr_en;
    logic             wait_end;

    assign req_ready_o = (state_q == ST_IDLE);
    assign fire        = req_valid_i && req_ready_o;
    assign wait_end    = (state_q == ST_WAIT) && (cnt_q == CNT_END);
    assign wr_en       = kind_i inside {K_ADD, K_ADD3, K_MULTI, K_UADD, K_SADD};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire && kind_i == K_MULTI) state_d = ST_WAIT;
            ST_WAIT: if (cnt_q == CNT_END)          state_d = ST_DONE;
            ST_DONE:                                state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_accept_o <= 1'b0;
            rsp_we_o     <= 1'b0;
            rsp_rd_o     <= '0;
            rsp_data_o   <= '0;
            rsp_exc_o    <= 1'b0;
            rsp_cause_o  <= '0;
        end else begin
            rsp_valid_o <= (fire && kind_i != K_MULTI) || wait_end;
            if (fire) begin
                rsp_accept_o <= (kind_i != K_NONE);
                rsp_we_o     <= wr_en;
                rsp_rd_o     <= wr_en ? rd_idx_i : '0;
                rsp_data_o   <= wr_en ? sum_i : '0;
                rsp_exc_o    <= (kind_i == K_EXC);
                rsp_cause_o  <= (kind_i == K_EXC) ? CAUSE_W'(cause_src_i) : '0;
            end
        end
    end

endmodule

// File: rtl/xcop_exec.sv
module xcop_exec
    import xcop_pkg::*;
#(
    parameter int unsigned MULTI_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [XLEN-1:0]      instr_i,
    input  logic [XLEN-1:0]      op_a_i,
    input  logic [XLEN-1:0]      op_b_i,
    input  logic [XLEN-1:0]      op_c_i,
    input  logic [1:0]           priv_i,
    output logic                 rsp_valid_o,
    output logic                 rsp_accept_o,
    output logic                 rsp_we_o,
    output logic [REG_IDX_W-1:0] rsp_rd_o,
    output logic [XLEN-1:0]      rsp_data_o,
    output logic                 rsp_exc_o,
    output logic [CAUSE_W-1:0]   rsp_cause_o
);

    op_kind_e        kind;
    logic [XLEN-1:0] sum;

    xcop_decode u_decode (
        .instr_i (instr_i),
        .priv_i  (priv_i),
        .kind_o  (kind)
    );

    xcop_alu #(.W(XLEN)) u_alu (
        .kind_i (kind),
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .c_i    (op_c_i),
        .sum_o  (sum)
    );

    xcop_ctrl #(.MULTI_LAT(MULTI_LAT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .kind_i       (kind),
        .rd_idx_i     (instr_i[11:7]),
        .cause_src_i  (instr_i[19:15]),
        .sum_i        (sum),
        .req_ready_o  (req_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_accept_o (rsp_accept_o),
        .rsp_we_o     (rsp_we_o),
        .rsp_rd_o     (rsp_rd_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_exc_o    (rsp_exc_o),
        .rsp_cause_o  (rsp_cause_o)
    );

endmodule

// File: rtl/xcop_exec_chk.sv
module xcop_exec_chk
    import xcop_pkg::*;
#(
    parameter int unsigned MULTI_LAT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic               req_ready_o,
    input logic [XLEN-1:0]    instr_i,
    input logic [1:0]         priv_i,
    input logic               rsp_valid_o,
    input logic               rsp_accept_o,
    input logic               rsp_we_o,
    input logic               rsp_exc_o,
    input logic [CAUSE_W-1:0] rsp_cause_o
);

    localparam int unsigned MC_W = $clog2(MULTI_LAT + 1);

    logic            fire;
    logic            opc_ok;
    logic            multi_enc;
    logic            uadd_enc;
    logic [MC_W-1:0] mc_cnt;

    assign fire      = req_valid_i && req_ready_o;
    assign opc_ok    = (instr_i[6:0] == OPC_CUSTOM3);
    assign multi_enc = opc_ok && instr_i[14:12] == F3_ARITH && instr_i[31:25] == F7_MULTI;
    assign uadd_enc  = opc_ok && instr_i[14:12] == F3_ARITH && instr_i[31:25] == F7_UADD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        mc_cnt <= '0;
        else if (fire && multi_enc)                        mc_cnt <= MC_W'(1);
        else if (mc_cnt != '0 && mc_cnt < MC_W'(MULTI_LAT)) mc_cnt <= mc_cnt + 1'b1;
        else                                               mc_cnt <= '0;
    end

    p_foreign_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !opc_ok) |=> (rsp_valid_o && !rsp_accept_o));

    p_single_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !multi_enc) |=> rsp_valid_o);

    p_multi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_cnt != '0 && mc_cnt < MC_W'(MULTI_LAT)) |-> (!rsp_valid_o && !req_ready_o));

    p_multi_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_cnt == MC_W'(MULTI_LAT)) |-> (rsp_valid_o && rsp_accept_o && rsp_we_o && !req_ready_o));

    p_user_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uadd_enc && priv_i != PRIV_USER) |=> (rsp_valid_o && !rsp_accept_o));

    p_exc_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_exc_o) |-> (rsp_accept_o && !rsp_we_o));

    p_exc_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_exc_o) |-> (rsp_cause_o[5] == 1'b0 && cause_known(rsp_cause_o[4:0])));

    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_accept_o) |-> (!rsp_we_o && !rsp_exc_o));

endmodule

bind xcop_exec xcop_exec_chk #(.MULTI_LAT(MULTI_LAT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .instr_i      (instr_i),
    .priv_i       (priv_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_accept_o (rsp_accept_o),
    .rsp_we_o     (rsp_we_o),
    .rsp_exc_o    (rsp_exc_o),
    .rsp_cause_o  (rsp_cause_o)
);

// File: tb/xcop_exec_tb_top.sv
module xcop_exec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] instr_i = '0;
    logic [31:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
    logic [1:0]  priv_i = 2'b11;
    logic        rsp_valid_o, rsp_accept_o, rsp_we_o, rsp_exc_o;
    logic [4:0]  rsp_rd_o;
    logic [31:0] rsp_data_o;
    logic [5:0]  rsp_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic        acc;
        logic        we;
        logic [4:0]  rd;
        logic [31:0] data;
        logic        exc;
        logic [5:0]  cause;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xcop_exec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .instr_i      (instr_i),
        .op_a_i       (op_a_i),
        .op_b_i       (op_b_i),
        .op_c_i       (op_c_i),
        .priv_i       (priv_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_accept_o (rsp_accept_o),
        .rsp_we_o     (rsp_we_o),
        .rsp_rd_o     (rsp_rd_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_exc_o    (rsp_exc_o),
        .rsp_cause_o  (rsp_cause_o)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b1111011};
    endfunction

    function automatic exp_t ok(input logic [4:0] rd, input logic [31:0] d, input string t);
        exp_t e;
        e.acc = 1; e.we = 1; e.rd = rd; e.data = d; e.exc = 0; e.cause = 0; e.tag = t;
        return e;
    endfunction

    function automatic exp_t rej(input string t);
        exp_t e;
        e.acc = 0; e.we = 0; e.rd = 0; e.data = 0; e.exc = 0; e.cause = 0; e.tag = t;
        return e;
    endfunction

    function automatic exp_t nowr(input logic x, input logic [5:0] c, input string t);
        exp_t e;
        e.acc = 1; e.we = 0; e.rd = 0; e.data = 0; e.exc = x; e.cause = c; e.tag = t;
        return e;
    endfunction

    task automatic check(input bit cond, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, act, expv);
        end
    endtask

    // Caller is at a falling edge; returns at the falling edge after the request is taken.
    task automatic send(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [1:0] pv, input exp_t e);
        while (!req_ready_o) @(negedge clk);
        instr_i = ins; op_a_i = a; op_b_i = b; op_c_i = c; priv_i = pv;
        req_valid_i = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Monitor: compares each response pulse with the oldest scoreboard entry.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected response", 32'(rsp_accept_o), 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_accept_o == e.acc && rsp_we_o == e.we && rsp_rd_o == e.rd &&
                          rsp_data_o == e.data && rsp_exc_o == e.exc && rsp_cause_o == e.cause,
                          e.tag,
                          {rsp_accept_o, rsp_we_o, rsp_exc_o, rsp_rd_o, rsp_cause_o, rsp_data_o[15:0]},
                          {e.acc, e.we, e.exc, e.rd, e.cause, e.data[15:0]});
                end
            end
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog expired got %0d exp 0", sb_q.size());
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready_o == 1'b1 && rsp_valid_o == 1'b0, "R11 reset state",
              {req_ready_o, rsp_valid_o}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready_o == 1'b1 && rsp_valid_o == 1'b0, "R11 after reset release",
              {req_ready_o, rsp_valid_o}, 32'h2);

        // R2 plain add, including wrap-around
        send(enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd5), 32'h10, 32'h20, 32'hFF, 2'b11,
             ok(5'd5, 32'h30, "R2 add"));
        send(enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd31), 32'hFFFF_FFFF, 32'h2, 32'h0, 2'b11,
             ok(5'd31, 32'h1, "R2 add wrap"));

        // R3 three-source add, rs3 index 7 in bits [31:27]
        send(enc({5'd7, 2'b01}, 5'd2, 5'd1, 3'b000, 5'd9), 32'h100, 32'h23, 32'h1000, 2'b11,
             ok(5'd9, 32'h1123, "R3 add3"));

        // R4 multi-cycle add with timing checks
        send(enc(7'b0001000, 5'd3, 5'd4, 3'b000, 5'd12), 32'h7000_0000, 32'h0000_0ABC, 32'h1, 2'b11,
             ok(5'd12, 32'h7000_0ABC, "R4 multi result"));
        for (int j = 1; j <= 4; j++) begin
            check(req_ready_o == 1'b0, "R4 ready low in window", 32'(req_ready_o), 32'h0);
            check(rsp_valid_o == (j == 4), "R4 valid only at end", 32'(rsp_valid_o), 32'(j == 4));
            @(negedge clk);
        end
        check(req_ready_o == 1'b1, "R4 ready back", 32'(req_ready_o), 32'h1);

        // R5 user add
        send(enc(7'b0000010, 5'd2, 5'd1, 3'b000, 5'd6), 32'd40, 32'd2, 32'd0, 2'b00,
             ok(5'd6, 32'd42, "R5 user add at user"));
        send(enc(7'b0000010, 5'd2, 5'd1, 3'b000, 5'd6), 32'd40, 32'd2, 32'd0, 2'b01,
             rej("R5 user add at supervisor"));
        send(enc(7'b0000010, 5'd2, 5'd1, 3'b000, 5'd6), 32'd40, 32'd2, 32'd0, 2'b11,
             rej("R5 user add at machine"));

        // R6 supervisor add
        send(enc(7'b0000110, 5'd2, 5'd1, 3'b000, 5'd7), 32'd5, 32'd6, 32'd0, 2'b01,
             ok(5'd7, 32'd11, "R6 super add at supervisor"));
        send(enc(7'b0000110, 5'd2, 5'd1, 3'b000, 5'd7), 32'd5, 32'd6, 32'd0, 2'b00,
             rej("R6 super add at user"));

        // R7 exception instruction with legal causes
        send(enc(7'b1100000, 5'd0, 5'd0, 3'b010, 5'd0), 32'h5, 32'h6, 32'h0, 2'b11,
             nowr(1'b1, 6'd0, "R7 exc cause 0"));
        send(enc(7'b1100000, 5'd0, 5'd9, 3'b010, 5'd0), 32'h5, 32'h6, 32'h0, 2'b11,
             nowr(1'b1, 6'd9, "R7 exc cause 9"));
        send(enc(7'b1100000, 5'd0, 5'd11, 3'b010, 5'd0), 32'h5, 32'h6, 32'h0, 2'b11,
             nowr(1'b1, 6'd11, "R7 exc cause 11"));
        send(enc(7'b1100000, 5'd0, 5'd15, 3'b010, 5'd0), 32'h5, 32'h6, 32'h0, 2'b11,
             nowr(1'b1, 6'd15, "R7 exc cause 15"));

        // R8 malformed exception instructions
        send(enc(7'b1100000, 5'd0, 5'd10, 3'b010, 5'd0), 0, 0, 0, 2'b11, rej("R8 exc cause 10"));
        send(enc(7'b1100000, 5'd0, 5'd14, 3'b010, 5'd0), 0, 0, 0, 2'b11, rej("R8 exc cause 14"));
        send(enc(7'b1100000, 5'd0, 5'd16, 3'b010, 5'd0), 0, 0, 0, 2'b11, rej("R8 exc cause 16"));
        send(enc(7'b1100000, 5'd0, 5'd3, 3'b010, 5'd4), 0, 0, 0, 2'b11, rej("R8 exc rd nonzero"));
        send(enc(7'b1100000, 5'd1, 5'd3, 3'b010, 5'd0), 0, 0, 0, 2'b11, rej("R8 exc rs2 nonzero"));

        // R9 no-op
        send(enc(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd8), 32'h55, 32'h66, 32'h0, 2'b11,
             nowr(1'b0, 6'd0, "R9 nop"));

        // R1 foreign opcode carrying add fields
        begin
            logic [31:0] w;
            w = enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd5);
            w[6:0] = 7'b0001011;
            send(w, 32'h1, 32'h2, 32'h0, 2'b11, rej("R1 foreign opcode"));
        end

        // R10 unmatched funct3/funct7 pairs
        send(enc(7'b0000001, 5'd2, 5'd1, 3'b001, 5'd5), 1, 2, 0, 2'b11, rej("R10 f3=001 f7=1"));
        send(enc(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd5), 1, 2, 0, 2'b11, rej("R10 f3=000 f7=0100000"));
        send(enc(7'b0000000, 5'd2, 5'd1, 3'b111, 5'd5), 1, 2, 0, 2'b11, rej("R10 f3=111"));

        // R11 back-to-back burst, ordering
        send(enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd1), 32'd1, 32'd1, 0, 2'b11, ok(5'd1, 32'd2, "R11 burst 0"));
        send(enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd2), 32'd2, 32'd2, 0, 2'b11, ok(5'd2, 32'd4, "R11 burst 1"));
        send(enc(7'h00, 5'd0, 5'd0, 3'b111, 5'd3), 32'd3, 32'd3, 0, 2'b11, rej("R11 burst 2"));
        send(enc(7'h00, 5'd2, 5'd1, 3'b001, 5'd4), 32'd4, 32'd4, 0, 2'b11, ok(5'd4, 32'd8, "R11 burst 3"));

        repeat (6) @(negedge clk);
        check(sb_q.size() == 0, "R11 all responses seen", 32'(sb_q.size()), 32'h0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule